// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a slower peripheral bus clock from the system clock with a programmable integer ratio between 1 and 128. Software controls it through one 32-bit control word: a divide field, an output enable, and a read-only ready flag that forms a handshake for divide changes.

A new divide value is accepted only while the ready flag is set. Once accepted, the value waits until the running output period has finished and then takes effect at the start of the next period. This means the output never shows a shortened or stretched pulse. The ready flag stays low from the accepting write until the new period begins. Clearing the enable holds the output low and keeps the period counter at its start.

The divided clock is a registered level. It follows the counter state one system clock later, so it is free of combinational glitches.

Top module: `pbus_clkdiv`

## Requirements
- R1: The read word carries the divide in effect in bits 6:0, the ready flag in bit 11 and the enable in bit 15, with every other bit zero. After reset it reads 0x0000_0800: divide field 0, ready set, enable clear, and the output is low.
- R2: With divide field value F and the enable set, the output period is F+1 system clock cycles.
- R3: The output is high for floor((F+1)/2) cycles of each period. For F=0 (ratio 1) the output stays high continuously while enabled.
- R4: A write while ready is set is accepted, and the ready flag reads low on the next cycle.
- R5: The divide field of a write made while ready is low is ignored: the value in effect afterwards is the previously accepted one. The enable bit of such a write still takes effect.
- R6: An accepted divide is loaded at the first period end after the write. On the cycle the new period begins, ready reads high again and the field reads back the new value.
- R7: While the enable is clear, the output is low and the period counter is held at its start. Once the enable is set again, the output goes high on the second cycle after the write, which starts a fresh period.
- R8: A divide change that is pending while the enable is clear completes on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| clk_out | output | 1 | Divided peripheral bus clock (registered) |

## Verification
An accepted write shows in the read word (enable and ready low) one cycle after the write edge. The enable reaches the output one cycle later, because the output register follows the counter state of the previous cycle. A pending divide appears in the read word on the cycle after the boundary that ends the old period. The bench keeps a behavioural per-cycle model that is advanced on each rising edge and compared with the read word and the output on every falling edge, so each latency is checked exactly. Directed checks add period and high-time measurements, the ignored write while not ready, and the disable and re-enable cases.

// File: rtl/pbus_clkdiv_pkg.sv
package pbus_clkdiv_pkg;
    localparam int REG_W     = 32;
    localparam int DIV_W     = 7;
    localparam int READY_POS = 11;
    localparam int EN_POS    = 15;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic en;
        logic rdy;
        logic pend;
        div_t act;
        div_t pdiv;
    } ctrl_t;

    typedef struct packed {
        div_t cnt;
        logic out;
    } core_t;

    localparam ctrl_t CTRL_RST = '{en: 1'b0, rdy: 1'b1, pend: 1'b0,
                                   act: '0, pdiv: '0};
    localparam core_t CORE_RST = '{cnt: '0, out: 1'b0};
endpackage

// File: rtl/pbus_clkdiv_ctrl.sv
module pbus_clkdiv_ctrl
    import pbus_clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_enable_bit,
    input  div_t wr_div,
    input  logic boundary,
    output logic en,
    output logic ready,
    output div_t act_div
);
    ctrl_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        // a pending divide is taken at the end of the running period
        if (s_q.pend && boundary) begin
            s_d.act  = s_q.pdiv;
            s_d.pend = 1'b0;
            s_d.rdy  = 1'b1;
        end
        if (wr_en) begin
            s_d.en = wr_enable_bit;
            if (s_q.rdy) begin
                s_d.pend = 1'b1;
                s_d.pdiv = wr_div;
                s_d.rdy  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTRL_RST;
        else        s_q <= s_d;
    end

    assign en      = s_q.en;
    assign ready   = s_q.rdy;
    assign act_div = s_q.act;
endmodule

// File: rtl/pbus_clkdiv_core.sv
module pbus_clkdiv_core
    import pbus_clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  div_t div,
    output logic boundary,
    output logic clk_out
);
    core_t s_q, s_d;

    logic [DIV_W:0] ratio;
    div_t           half;
    logic           high;

    always_comb begin
        ratio    = {1'b0, div} + 1'b1;
        half     = ratio[DIV_W:1];
        high     = (div == '0) || (s_q.cnt < half);
        boundary = !en || (s_q.cnt == div);

        s_d      = s_q;
        s_d.out  = en && high;
        s_d.cnt  = boundary ? '0 : s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CORE_RST;
        else        s_q <= s_d;
    end

    assign clk_out = s_q.out;
endmodule

// File: rtl/pbus_clkdiv_readback.sv
module pbus_clkdiv_readback
    import pbus_clkdiv_pkg::*;
(
    input  logic             en,
    input  logic             ready,
    input  div_t             act_div,
    output logic [REG_W-1:0] rd_data
);
    always_comb begin
        rd_data            = '0;
        rd_data[DIV_W-1:0] = act_div;
        rd_data[READY_POS] = ready;
        rd_data[EN_POS]    = en;
    end
endmodule

// File: rtl/pbus_clkdiv.sv
module pbus_clkdiv
    import pbus_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_out
);
    logic en;
    logic ready;
    div_t act_div;
    logic boundary;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[REG_W-1:EN_POS+1], wr_data[EN_POS-1:DIV_W]};

    pbus_clkdiv_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_enable_bit (wr_data[EN_POS]),
        .wr_div        (wr_data[DIV_W-1:0]),
        .boundary      (boundary),
        .en            (en),
        .ready         (ready),
        .act_div       (act_div)
    );

    pbus_clkdiv_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .div      (act_div),
        .boundary (boundary),
        .clk_out  (clk_out)
    );

    pbus_clkdiv_readback u_rb (
        .en      (en),
        .ready   (ready),
        .act_div (act_div),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/pbus_clkdiv_chk.sv
module pbus_clkdiv_chk
    import pbus_clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             clk_out,
    input logic             boundary
);
    logic rdy;
    logic ena;
    assign rdy = rd_data[READY_POS];
    assign ena = rd_data[EN_POS];

    assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rdy) |=> !rdy);

    assert_field_only_on_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data[DIV_W-1:0]) |-> $rose(rdy));

    assert_load_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(boundary));

    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ena |=> !clk_out);

    assert_new_period_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy) && ena) |=> clk_out);

    assert_spare_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~32'h0000_887F) == '0);

    logic unused_chk;
    assign unused_chk = ^wr_data;
endmodule

bind pbus_clkdiv pbus_clkdiv_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .clk_out  (clk_out),
    .boundary (boundary)
);

// File: tb/sim_pbus_clkdiv.sv
`timescale 1ns/1ps
module sim_pbus_clkdiv;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        clk_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pbus_clkdiv u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_out (clk_out)
    );

    // behavioural reference state
    int m_en, m_rdy, m_pend, m_act, m_pdiv, m_cnt, m_out;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_rdy = 1; m_pend = 0; m_act = 0; m_pdiv = 0; m_cnt = 0; m_out = 0;
        end else begin
            int ends, n_out, n_cnt;
            ends  = (m_en == 0) || (m_cnt == m_act);
            n_out = (m_en != 0) && ((m_act == 0) || (m_cnt < (m_act + 1) / 2));
            n_cnt = ends ? 0 : m_cnt + 1;
            if (m_pend && ends) begin
                m_act = m_pdiv; m_pend = 0; m_rdy = 1;
            end else if (wr_en && m_rdy) begin
                m_pend = 1; m_pdiv = int'(wr_data[6:0]); m_rdy = 0;
            end
            if (wr_en) m_en = int'(wr_data[15]);
            m_out = n_out;
            m_cnt = n_cnt;
        end
    end

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w       = '0;
        w[6:0]  = 7'(m_act);
        w[11]   = (m_rdy != 0);
        w[15]   = (m_en != 0);
        return w;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] e;
            e = model_word();
            checks++;
            if (rd_data[6:0] !== e[6:0]) begin
                fails++;
                $display("FAIL R6 field actual=%0d expected=%0d at %0t", rd_data[6:0], e[6:0], $time);
            end else if (rd_data[11] !== e[11]) begin
                fails++;
                $display("FAIL R4 ready actual=%0b expected=%0b at %0t", rd_data[11], e[11], $time);
            end else if (rd_data !== e) begin
                fails++;
                $display("FAIL R1 word actual=%h expected=%h at %0t", rd_data, e, $time);
            end
            checks++;
            if (clk_out !== (m_out != 0)) begin
                fails++;
                $display("FAIL R3 clk_out actual=%0b expected=%0b at %0t", clk_out, m_out, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400 && !rd_data[11]; i++) @(negedge clk);
    endtask

    task automatic measure(input int exp_p, input int exp_h, input string tag);
        int p, h;
        logic prev;
        prev = clk_out;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (clk_out && !prev) break;
            prev = clk_out;
        end
        p = 0; h = 0;
        for (int i = 0; i < 600; i++) begin
            if (clk_out) h++;
            p++;
            prev = clk_out;
            @(negedge clk);
            if (clk_out && !prev) break;
        end
        chk(p == exp_p, {tag, " period"}, p, exp_p);
        chk(h == exp_h, {tag, " high time"}, h, exp_h);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 32'h0000_0800, "R1 reset word", int'(rd_data), 32'h800);
        chk(clk_out == 1'b0, "R1 reset output", int'(clk_out), 0);

        wr(32'h0000_8003);
        chk(rd_data[11] == 1'b0, "R4 ready low", int'(rd_data[11]), 0);
        wr(32'h0000_8010);                       // while not ready: field ignored
        wait_ready();
        chk(rd_data[6:0] == 7'd3, "R5 ignored field", int'(rd_data[6:0]), 3);
        chk(rd_data[15] == 1'b1, "R5 enable kept", int'(rd_data[15]), 1);
        measure(4, 2, "R2 ratio4");

        wr(32'h0000_8004);
        wait_ready();
        chk(rd_data[6:0] == 7'd4, "R6 readback", int'(rd_data[6:0]), 4);
        measure(5, 2, "R3 odd ratio5");

        wr(32'h0000_8000);
        wait_ready();
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk(clk_out == 1'b1, "R3 ratio1 high", int'(clk_out), 1);
            @(negedge clk);
        end

        wr(32'h0000_807F);
        wait_ready();
        measure(128, 64, "R2 ratio128");

        wr(32'h0000_0005);
        chk(rd_data[11] == 1'b0, "R4 ready low on disable", int'(rd_data[11]), 0);
        @(negedge clk);
        chk(rd_data[11] == 1'b1, "R8 ready back", int'(rd_data[11]), 1);
        chk(rd_data[6:0] == 7'd5, "R8 field loaded", int'(rd_data[6:0]), 5);
        for (int i = 0; i < 8; i++) begin
            chk(clk_out == 1'b0, "R7 output low", int'(clk_out), 0);
            @(negedge clk);
        end

        wr(32'h0000_8005);
        @(negedge clk);
        chk(clk_out == 1'b1, "R7 restart high", int'(clk_out), 1);
        wait_ready();
        measure(6, 3, "R2 ratio6");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule